// File: doc/BRIEF.md
# Way-Predicting Set-Associative Cache Lookup

This block is the read lookup path of a small set-associative cache. Each set keeps a short field that names the way most likely to hold the next line requested from that set. When a request arrives, that field steers the data multiplexer at once, and only the named way's tag is compared, alongside the data read. A correct guess answers one cycle after acceptance.

When the guess is wrong, the remaining ways are compared in the following cycle, and a hit found there answers one cycle later with a slow-hit flag. If no way matches, the block asks the next level for the whole line. The refilled line is installed in a victim way: an empty way if the set has one, otherwise the way named by a per-set rotating pointer. The requested word is then returned. The predictor is retrained on every hit and on every refill.

The block takes one request at a time. Its ready output is low during a second-cycle check and during a refill.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, every way of every set is empty, req_ready is 1, and resp_valid and mem_req_valid are 0. The first access to any line is therefore a miss.
- R2: A request whose line sits in the predicted way is answered in the cycle after acceptance, with resp_hit=1 and resp_slow_hit=0. req_ready stays 1, so requests may follow back to back.
- R3: A request whose line sits in a way other than the predicted one is answered two cycles after acceptance, with resp_hit=1 and resp_slow_hit=1. req_ready is 0 in the cycle between acceptance and the answer.
- R4: After any hit, the set's prediction names the way that hit, so the next access to that line is a one-cycle hit.
- R5: On a miss, mem_req_valid rises two cycles after acceptance and stays high with a stable mem_req_addr equal to the request address shifted right by 6 (the line address) until refill_valid is seen. req_ready stays 0 throughout. The answer comes in the cycle after refill_valid, with resp_hit=0 and resp_slow_hit=0.
- R6: After a refill, the set's prediction names the way just filled, so an immediate re-access of that line is a one-cycle hit.
- R7: The victim way is the lowest-numbered empty way of the set. When all ways are full, the victim is the way named by the set's rotating pointer. That pointer resets to 0 and, after every refill, becomes the victim number plus 1, modulo the way count.
- R8: The returned word is 32 bits and is selected by address bits [5:2]. Word i of a line occupies bits [32i+31:32i] of refill_data.
- R9: req_valid is ignored while req_ready is 0. Exactly one answer is produced per accepted request, and it belongs to that request.
- R10: Sets are independent. Fills, hits and predictor updates in one set do not change the outcome of accesses to another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 16 | Byte address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | Answer present, one cycle pulse |
| resp_data | output | 32 | Requested word |
| resp_hit | output | 1 | 1 if the line was present, 0 if it was refilled |
| resp_slow_hit | output | 1 | Hit found only by the second-cycle check |
| mem_req_valid | output | 1 | Line request to the next level |
| mem_req_addr | output | 10 | Line address for the next level |
| refill_valid | input | 1 | Refill line present |
| refill_data | input | 512 | Whole refill line |

## Verification
A corrupted prediction field does not change the returned data. It does show at the ports, as a hit that takes two cycles with resp_slow_hit set on the very next access to the retrained line. A wrong valid bit, tag or rotating pointer shows up as a miss, or as a missing miss, within a few accesses to the same set, because the bench's own model predicts each answer's latency and flags. A wrong victim choice shows up once the set has been cycled through more lines than it has ways. Wrong word selection or wrong line placement appears directly in resp_data on the same access.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FILL  = 2'd2
    } wp_state_e;

endpackage

// File: rtl/wp_way_match.sv
module wp_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 7,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [TAG_W-1:0]           tag_i,
    input  logic [WAY_W-1:0]           skip_i,
    output logic [WAYS-1:0]            hit_vec_o,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);

    // One comparator per way; the way already tried in the first cycle is masked.
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (WAY_W'(g) != skip_i) && (tags_i[g] == tag_i);
    end

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec_o[w]) way_o = WAY_W'(w);
        end
    end

    assign hit_o = |hit_vec_o;

endmodule

// File: rtl/wp_victim_pick.sv
module wp_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] victim_o
);

    // Lowest empty way wins; otherwise the rotating pointer names the victim.
    always_comb begin
        victim_o = rr_i;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) victim_o = WAY_W'(w);
        end
    end

endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup #(
    parameter int ADDR_W     = 16,
    parameter int WAYS       = 4,
    parameter int SETS       = 8,
    parameter int LINE_BYTES = 64,
    parameter int WORD_W     = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_valid,
    input  logic [ADDR_W-1:0]                      req_addr,
    output logic                                   req_ready,
    output logic                                   resp_valid,
    output logic [WORD_W-1:0]                      resp_data,
    output logic                                   resp_hit,
    output logic                                   resp_slow_hit,
    output logic                                   mem_req_valid,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   mem_req_addr,
    input  logic                                   refill_valid,
    input  logic [LINE_BYTES*8-1:0]                refill_data
);
    import wp_cache_pkg::*;

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFF_W - BYTE_W;

    typedef struct packed {
        wp_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [WAY_W-1:0]  pway;
        logic              rv;
        logic [WORD_W-1:0] rdata;
        logic              rhit;
        logic              rslow;
    } ctl_t;

    ctl_t c_d, c_q;

    // Per-set storage
    logic [WAYS-1:0]              valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
    logic [WAYS-1:0][LINE_W-1:0]  data_q  [SETS];
    logic [WAY_W-1:0]             pred_q  [SETS];
    logic [WAY_W-1:0]             rr_q    [SETS];

    // Request-side (first cycle) decode
    logic [SET_W-1:0]  in_set;
    logic [TAG_W-1:0]  in_tag;
    logic [WSEL_W-1:0] in_word;
    logic [WAY_W-1:0]  in_pway;
    logic [LINE_W-1:0] early_line;
    logic              first_hit;

    assign in_set     = req_addr[OFF_W +: SET_W];
    assign in_tag     = req_addr[ADDR_W-1 -: TAG_W];
    assign in_word    = req_addr[BYTE_W +: WSEL_W];
    assign in_pway    = pred_q[in_set];
    assign early_line = data_q[in_set][in_pway];   // mux steered before the compare resolves
    assign first_hit  = valid_q[in_set][in_pway] && (tag_q[in_set][in_pway] == in_tag);

    // Held-request decode (second cycle and refill)
    logic [SET_W-1:0]  h_set;
    logic [TAG_W-1:0]  h_tag;
    logic [WSEL_W-1:0] h_word;
    logic [WAYS-1:0]   chk_vec;
    logic              chk_hit;
    logic [WAY_W-1:0]  chk_way;
    logic [WAY_W-1:0]  victim;

    assign h_set  = c_q.addr[OFF_W +: SET_W];
    assign h_tag  = c_q.addr[ADDR_W-1 -: TAG_W];
    assign h_word = c_q.addr[BYTE_W +: WSEL_W];

    wp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_match (
        .tags_i    (tag_q[h_set]),
        .valid_i   (valid_q[h_set]),
        .tag_i     (h_tag),
        .skip_i    (c_q.pway),
        .hit_vec_o (chk_vec),
        .hit_o     (chk_hit),
        .way_o     (chk_way)
    );

    wp_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) i_victim (
        .valid_i  (valid_q[h_set]),
        .rr_i     (rr_q[h_set]),
        .victim_o (victim)
    );

    logic             fill_we;
    logic             pred_we;
    logic [WAY_W-1:0] pred_val;

    always_comb begin
        c_d      = c_q;
        c_d.rv   = 1'b0;
        fill_we  = 1'b0;
        pred_we  = 1'b0;
        pred_val = c_q.pway;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.addr = req_addr;
                    c_d.pway = in_pway;
                    if (first_hit) begin
                        c_d.rv    = 1'b1;
                        c_d.rhit  = 1'b1;
                        c_d.rslow = 1'b0;
                        c_d.rdata = early_line[in_word*WORD_W +: WORD_W];
                    end else begin
                        c_d.st = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                if (chk_hit) begin
                    c_d.rv    = 1'b1;
                    c_d.rhit  = 1'b1;
                    c_d.rslow = 1'b1;
                    c_d.rdata = data_q[h_set][chk_way][h_word*WORD_W +: WORD_W];
                    pred_we   = 1'b1;
                    pred_val  = chk_way;
                    c_d.st    = ST_IDLE;
                end else begin
                    c_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (refill_valid) begin
                    fill_we   = 1'b1;
                    pred_we   = 1'b1;
                    pred_val  = victim;
                    c_d.rv    = 1'b1;
                    c_d.rhit  = 1'b0;
                    c_d.rslow = 1'b0;
                    c_d.rdata = refill_data[h_word*WORD_W +: WORD_W];
                    c_d.st    = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                pred_q[s]  <= '0;
                rr_q[s]    <= '0;
            end
        end else begin
            c_q <= c_d;
            if (pred_we) pred_q[h_set] <= pred_val;
            if (fill_we) begin
                valid_q[h_set][victim] <= 1'b1;
                rr_q[h_set]            <= victim + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_q[h_set][victim]  <= h_tag;
            data_q[h_set][victim] <= refill_data;
        end
    end

    assign req_ready     = (c_q.st == ST_IDLE);
    assign resp_valid    = c_q.rv;
    assign resp_data     = c_q.rdata;
    assign resp_hit      = c_q.rhit;
    assign resp_slow_hit = c_q.rslow;
    assign mem_req_valid = (c_q.st == ST_FILL);
    assign mem_req_addr  = c_q.addr[ADDR_W-1:OFF_W];

    logic unused_low_bits;
    assign unused_low_bits = ^{req_addr[BYTE_W-1:0], c_q.addr[BYTE_W-1:0]};

    AST_FAST_HIT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit && !resp_slow_hit |-> $past(req_valid && req_ready)); // R2
    AST_SLOW_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_slow_hit |-> resp_hit); // R3
    AST_SLOW_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_slow_hit |-> $past(!req_ready)); // R3
    AST_SECOND_CHECK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready && !mem_req_valid |-> $onehot0(chk_vec)); // R3
    AST_FILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R5
    AST_REFILL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && refill_valid |=> resp_valid && !resp_hit && req_ready); // R5
    AST_MEM_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && $past(mem_req_valid) |-> $stable(mem_req_addr)); // R5
    AST_VICTIM_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !(&valid_q[h_set]) |-> !valid_q[h_set][victim]); // R7

endmodule

// File: tb/test_wp_cache_lookup.sv
module test_wp_cache_lookup;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [15:0]  req_addr = '0;
    logic         req_ready;
    logic         resp_valid;
    logic [31:0]  resp_data;
    logic         resp_hit;
    logic         resp_slow_hit;
    logic         mem_req_valid;
    logic [9:0]   mem_req_addr;
    logic         refill_valid = 1'b0;
    logic [511:0] refill_data = '0;

    always #2 clk = ~clk;  // 250 MHz

    wp_cache_lookup i_wp_cache_lookup (
        .clk, .rst_n, .req_valid, .req_addr, .req_ready,
        .resp_valid, .resp_data, .resp_hit, .resp_slow_hit,
        .mem_req_valid, .mem_req_addr, .refill_valid, .refill_data
    );

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    // Reference model state built from the requirements
    bit  m_valid [8][4];
    int  m_tag   [8][4];
    int  m_pred  [8];
    int  m_rr    [8];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [9:0] la, input int i);
        return {la, 2'b00, i[3:0], 16'hC0DE};
    endfunction

    function automatic logic [511:0] line_of(input logic [9:0] la);
        logic [511:0] l;
        for (int i = 0; i < 16; i++) l[i*32 +: 32] = word_of(la, i);
        return l;
    endfunction

    // kind: 0 predicted hit, 1 second-cycle hit, 2 miss
    task automatic access(input int tg, input int st, input int wd, input bit noise, input string lbl);
        logic [15:0] a;
        int kind, pw, hitw, v, cyc, waitn, fill_cyc, first_mem;
        bit seen;
        a = {tg[6:0], st[2:0], wd[3:0], 2'b00};
        pw = m_pred[st];
        hitw = -1;
        if (m_valid[st][pw] && m_tag[st][pw] == tg) kind = 0;
        else begin
            for (int w = 0; w < 4; w++) if (m_valid[st][w] && m_tag[st][w] == tg) hitw = w;
            kind = (hitw >= 0) ? 1 : 2;
        end
        if (kind == 1) m_pred[st] = hitw;  // R4
        if (kind == 2) begin               // R6, R7
            v = m_rr[st];
            for (int w = 3; w >= 0; w--) if (!m_valid[st][w]) v = w;
            m_valid[st][v] = 1;
            m_tag[st][v] = tg;
            m_pred[st] = v;
            m_rr[st] = (v + 1) % 4;
        end

        @(negedge clk);
        chk(req_ready == 1'b1, {lbl, " R2 ready before request"}, req_ready, 1);
        req_valid = 1'b1;
        req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; waitn = 0; seen = 0; fill_cyc = -10; first_mem = -1;
        if (kind == 0) chk(req_ready == 1'b1, {lbl, " R2 ready kept"}, req_ready, 1);
        else           chk(req_ready == 1'b0, {lbl, " R3 ready low after miss of guess"}, req_ready, 0);
        while (!resp_valid && cyc < 40) begin
            req_valid = 1'b0;
            refill_valid = 1'b0;
            if (!req_ready && noise) begin  // R9 ignored requests
                req_valid = 1'b1;
                req_addr = a ^ 16'h8040;
            end
            if (mem_req_valid) begin
                if (!seen) begin
                    seen = 1;
                    first_mem = cyc;
                    chk(mem_req_addr == a[15:6], {lbl, " R5 line address"}, mem_req_addr, a[15:6]);
                end
                waitn++;
                if (waitn == 3) begin
                    refill_valid = 1'b1;
                    refill_data = line_of(mem_req_addr);
                    fill_cyc = cyc;
                end
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        refill_valid = 1'b0;
        chk(resp_valid == 1'b1, {lbl, " R9 answer present"}, resp_valid, 1);
        case (kind)
            0: begin
                chk(cyc == 1, {lbl, " R2/R4 fast latency"}, cyc, 1);
                chk({resp_hit, resp_slow_hit} == 2'b10, {lbl, " R2 flags"}, {resp_hit, resp_slow_hit}, 2);
            end
            1: begin
                chk(cyc == 2, {lbl, " R3 slow latency"}, cyc, 2);
                chk({resp_hit, resp_slow_hit} == 2'b11, {lbl, " R3 flags"}, {resp_hit, resp_slow_hit}, 3);
            end
            default: begin
                chk(first_mem == 2, {lbl, " R5 request timing"}, first_mem, 2);
                chk(cyc == fill_cyc + 1, {lbl, " R5 refill latency"}, cyc, fill_cyc + 1);
                chk({resp_hit, resp_slow_hit} == 2'b00, {lbl, " R5 flags"}, {resp_hit, resp_slow_hit}, 0);
            end
        endcase
        if (kind != 2) chk(seen == 0, {lbl, " R5 no line request on hit"}, seen, 0);
        chk(resp_data == word_of(a[15:6], wd), {lbl, " R8 data"}, resp_data, word_of(a[15:6], wd));
        @(negedge clk);
        chk(resp_valid == 1'b0, {lbl, " R9 single answer"}, resp_valid, 0);
    endtask

    initial begin
        int seed;
        for (int s = 0; s < 8; s++) begin
            m_pred[s] = 0;
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 0;
                m_tag[s][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1 no answer after reset", resp_valid, 0);
        chk(mem_req_valid == 1'b0, "R1 no line request after reset", mem_req_valid, 0);

        // Directed sequence in set 2
        access(10, 2, 3, 0, "R1 first access");
        access(10, 2, 7, 0, "R6 re-access after fill");
        access(11, 2, 0, 1, "R7 second empty way");
        access(12, 2, 15, 0, "R7 third empty way");
        access(13, 2, 1, 1, "R7 fourth empty way");
        access(10, 2, 4, 0, "R3 other way");
        access(10, 2, 5, 0, "R4 retrained");
        access(14, 2, 2, 1, "R7 pointer eviction");
        access(10, 2, 6, 0, "R7 evicted line");
        access(12, 2, 9, 0, "R3 surviving line");
        access(3, 5, 8, 1, "R10 other set untouched");

        // Near-exhaustive pseudo-random sweep over all sets and six tags per set
        seed = 7;
        for (int n = 0; n < 600; n++) begin
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            access((seed >> 4) % 6, (seed >> 10) % 8, (seed >> 16) % 16, (n % 3) == 0, "R10 sweep");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule